// File: doc/BRIEF.md
# Windowed Event Counter Unit

This block counts processor events on four channels inside one shared measurement window. Each channel has its own event-select register. The register either picks one of the incoming event lines or leaves the channel idle. The processor events come in as per-cycle pulses or levels on an event bus. The block does not generate them.

The window can be opened and closed in three ways:
- by the start of program execution and the next break;
- by break condition A followed by break condition B;
- by break condition B followed by break condition A.

After the window closes it stays closed until the unit is re-armed or cleared. A counter that runs past its top value sticks at all-ones and raises a sticky overflow flag for its channel. Counting pauses while the processor clock is stopped, which is signalled by a clock-enable input.

Top module: `perf_window_counters`

## Requirements
- R1: After reset all counters read 0, all overflow flags are 0, the window is neither open nor done, and every event select is 0 (channel disabled).
- R2: Select code k in 1..NUM_EV makes a channel count cycles in which `ev_i[k-1]` is high. Code 0 disables the channel, and so does any code above NUM_EV. A write through `sel_we_i`/`sel_ch_i`/`sel_val_i` takes effect from the next cycle. A clear does not change the selects.
- R3: A channel whose select code equals BRANCH_SEL adds 2 per counted event. All other codes add 1.
- R4: A cycle is counted only when the window was already open at the start of that cycle. The cycle of the opening trigger is therefore not counted. The cycle of the closing trigger is counted.
- R5: In run mode (`mode_i`=0) the window opens on `go_i` and closes on `brk_i`.
- R6: In mode 1 the window opens on `trig_a_i` and closes on `trig_b_i`. In mode 2 it opens on `trig_b_i` and closes on `trig_a_i`. The closing trigger has no effect while the window is idle, and the opening trigger has no effect while the window is open.
- R7: Once the window has closed (done), opening triggers are ignored and counts are frozen until `arm_i` or `clear_i`. `arm_i` returns the window to idle and keeps counts and overflow flags.
- R8: A counter that would pass 2^CNT_W−1 holds at all-ones and sets its overflow flag. The flag stays set through re-arm and is reset only by `clear_i` or reset.
- R9: `clear_i` zeroes all counters and overflow flags and returns the window to idle. It has priority over triggers, arming and counting in the same cycle.
- R10: While `cpu_clk_en_i` is low, counters hold their values even with the window open.
- R11: `cfg_err_o` is high when `mode_i` is 3, or when `mode_i` is 1 or 2 with every channel disabled. While it is high the window does not open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_clk_en_i | input | 1 | High while the processor clock runs |
| ev_i | input | NUM_EV | Event lines, sampled each cycle |
| mode_i | input | 2 | Window mode: 0 run-to-break, 1 A then B, 2 B then A, 3 invalid |
| go_i | input | 1 | Program execution start pulse |
| brk_i | input | 1 | Break pulse |
| trig_a_i | input | 1 | Break condition A pulse |
| trig_b_i | input | 1 | Break condition B pulse |
| arm_i | input | 1 | Return window to idle, keep counts |
| clear_i | input | 1 | Clear counts, overflow flags and window |
| sel_we_i | input | 1 | Event-select write strobe |
| sel_ch_i | input | CH_W | Channel written |
| sel_val_i | input | SEL_W | Select code written |
| cnt_o | output | NUM_CH*CNT_W | Counter values, channel c at bits [c*CNT_W +: CNT_W] |
| ovf_o | output | NUM_CH | Sticky overflow flags |
| win_open_o | output | 1 | Window open |
| win_done_o | output | 1 | Window closed, waiting for arm or clear |
| cfg_err_o | output | 1 | Invalid window configuration |

## Verification
The bench builds the block with four channels, eight event lines and BRANCH_SEL of 3, but narrows the counters to 6 bits. With the narrow counters, saturation and the sticky overflow flag are reached within a few dozen cycles. They include the edge where a branch count of 62 steps to the all-ones value rather than to 63 plus one. Eight event lines give a 4-bit select, so codes above NUM_EV exist and can be shown to disable a channel.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_OPEN = 2'd1,
        WIN_DONE = 2'd2
    } win_state_e;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_A_TO_B = 2'd1,
        MODE_B_TO_A = 2'd2,
        MODE_RSVD   = 2'd3
    } win_mode_e;

endpackage

// File: rtl/pwc_window.sv
module pwc_window
    import pwc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       arm_i,
    input  logic       go_i,
    input  logic       brk_i,
    input  logic       trig_a_i,
    input  logic       trig_b_i,
    input  logic [1:0] mode_i,
    input  logic       any_en_i,
    output logic       open_o,
    output logic       done_o,
    output logic       err_o
);

    typedef struct packed {
        win_state_e st;
    } win_regs_t;

    win_regs_t win_d, win_q;
    win_mode_e mode;
    logic      start, stop, err;

    always_comb begin
        mode  = win_mode_e'(mode_i);
        err   = 1'b0;
        start = 1'b0;
        stop  = 1'b0;
        unique case (mode)
            MODE_RUN: begin
                start = go_i;
                stop  = brk_i;
            end
            MODE_A_TO_B: begin
                start = trig_a_i;
                stop  = trig_b_i;
                err   = !any_en_i;
            end
            MODE_B_TO_A: begin
                start = trig_b_i;
                stop  = trig_a_i;
                err   = !any_en_i;
            end
            default: begin
                err = 1'b1;
            end
        endcase

        win_d = win_q;
        if (clr_i || arm_i) begin
            win_d.st = WIN_IDLE;
        end else begin
            unique case (win_q.st)
                WIN_IDLE: if (start && !err) win_d.st = WIN_OPEN;
                WIN_OPEN: if (stop) win_d.st = WIN_DONE;
                default:  win_d.st = win_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '{st: WIN_IDLE};
        else        win_q <= win_d;
    end

    assign open_o = (win_q.st == WIN_OPEN);
    assign done_o = (win_q.st == WIN_DONE);
    assign err_o  = err;

endmodule

// File: rtl/pwc_event_mux.sv
module pwc_event_mux #(
    parameter int NUM_EV     = 8,
    parameter int SEL_W      = 4,
    parameter int BRANCH_SEL = 3
) (
    input  logic [NUM_EV-1:0] ev_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [1:0]        inc_o,
    output logic              active_o
);

    logic hit;

    always_comb begin
        hit      = 1'b0;
        active_o = 1'b0;
        for (int k = 0; k < NUM_EV; k++) begin
            if (sel_i == SEL_W'(k + 1)) begin
                hit      = ev_i[k];
                active_o = 1'b1;
            end
        end
        if (!hit)                                inc_o = 2'd0;
        else if (sel_i == SEL_W'(BRANCH_SEL))    inc_o = 2'd2;
        else                                     inc_o = 2'd1;
    end

endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [1:0]       inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctr_regs_t;

    ctr_regs_t ctr_d, ctr_q;
    logic [CNT_W:0] sum;

    always_comb begin
        sum   = {1'b0, ctr_q.cnt} + {{(CNT_W-1){1'b0}}, inc_i};
        ctr_d = ctr_q;
        if (clr_i) begin
            ctr_d = '0;
        end else if (en_i && (inc_i != 2'd0)) begin
            if (sum[CNT_W]) begin
                ctr_d.cnt = '1;
                ctr_d.ovf = 1'b1;
            end else begin
                ctr_d.cnt = sum[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cnt_o = ctr_q.cnt;
    assign ovf_o = ctr_q.ovf;

endmodule

// File: rtl/perf_window_counters.sv
module perf_window_counters #(
    parameter  int NUM_CH     = 4,
    parameter  int CNT_W      = 32,
    parameter  int NUM_EV     = 8,
    parameter  int BRANCH_SEL = 3,
    localparam int SEL_W      = $clog2(NUM_EV + 1),
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_clk_en_i,
    input  logic [NUM_EV-1:0]       ev_i,
    input  logic [1:0]              mode_i,
    input  logic                    go_i,
    input  logic                    brk_i,
    input  logic                    trig_a_i,
    input  logic                    trig_b_i,
    input  logic                    arm_i,
    input  logic                    clear_i,
    input  logic                    sel_we_i,
    input  logic [CH_W-1:0]         sel_ch_i,
    input  logic [SEL_W-1:0]        sel_val_i,
    output logic [NUM_CH*CNT_W-1:0] cnt_o,
    output logic [NUM_CH-1:0]       ovf_o,
    output logic                    win_open_o,
    output logic                    win_done_o,
    output logic                    cfg_err_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][SEL_W-1:0] sel;
    } sel_regs_t;

    sel_regs_t         sel_d, sel_q;
    logic [NUM_CH-1:0] ch_active;
    logic              count_en;

    always_comb begin
        sel_d = sel_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_we_i && (sel_ch_i == CH_W'(c))) sel_d.sel[c] = sel_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    pwc_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clear_i),
        .arm_i    (arm_i),
        .go_i     (go_i),
        .brk_i    (brk_i),
        .trig_a_i (trig_a_i),
        .trig_b_i (trig_b_i),
        .mode_i   (mode_i),
        .any_en_i (|ch_active),
        .open_o   (win_open_o),
        .done_o   (win_done_o),
        .err_o    (cfg_err_o)
    );

    assign count_en = win_open_o && cpu_clk_en_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [1:0] inc;

        pwc_event_mux #(
            .NUM_EV     (NUM_EV),
            .SEL_W      (SEL_W),
            .BRANCH_SEL (BRANCH_SEL)
        ) u_mux (
            .ev_i     (ev_i),
            .sel_i    (sel_q.sel[c]),
            .inc_o    (inc),
            .active_o (ch_active[c])
        );

        pwc_counter #(
            .CNT_W (CNT_W)
        ) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clear_i),
            .en_i  (count_en),
            .inc_i (inc),
            .cnt_o (cnt_o[c*CNT_W +: CNT_W]),
            .ovf_o (ovf_o[c])
        );
    end

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cpu_clk_en_i,
    input logic                    arm_i,
    input logic                    clear_i,
    input logic [NUM_CH*CNT_W-1:0] cnt_o,
    input logic [NUM_CH-1:0]       ovf_o,
    input logic                    win_open_o,
    input logic                    win_done_o,
    input logic                    cfg_err_o
);

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open_o && !clear_i) |=> $stable(cnt_o)); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done_o && !arm_i && !clear_i) |=> win_done_o); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o))); // R8

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_o == '0 && ovf_o == '0 && !win_open_o && !win_done_o)); // R9

    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en_i && !clear_i) |=> $stable(cnt_o)); // R10

    AST_ERR_BLOCKS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && !win_open_o) |=> !win_open_o); // R11

endmodule

bind perf_window_counters pwc_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_pwc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_clk_en_i (cpu_clk_en_i),
    .arm_i        (arm_i),
    .clear_i      (clear_i),
    .cnt_o        (cnt_o),
    .ovf_o        (ovf_o),
    .win_open_o   (win_open_o),
    .win_done_o   (win_done_o),
    .cfg_err_o    (cfg_err_o)
);

// File: tb/tb_perf_window_counters.sv
module tb_perf_window_counters;

    localparam int NUM_CH = 4;
    localparam int CNT_W  = 6;
    localparam int NUM_EV = 8;
    localparam int BR_SEL = 3;
    localparam int SEL_W  = $clog2(NUM_EV + 1);
    localparam int CH_W   = 2;
    localparam int MAXV   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_clk_en = 1'b1;
    logic [NUM_EV-1:0] ev = '0;
    logic [1:0] mode = 2'd0;
    logic go = 0, brk = 0, ta = 0, tb = 0, arm = 0, clr = 0, swe = 0;
    logic [CH_W-1:0] sch = '0;
    logic [SEL_W-1:0] sval = '0;
    logic [NUM_CH*CNT_W-1:0] cnt;
    logic [NUM_CH-1:0] ovf;
    logic wopen, wdone, cerr;

    always #2 clk = ~clk;

    perf_window_counters #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .NUM_EV(NUM_EV), .BRANCH_SEL(BR_SEL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cpu_clk_en_i(cpu_clk_en), .ev_i(ev),
        .mode_i(mode), .go_i(go), .brk_i(brk), .trig_a_i(ta), .trig_b_i(tb),
        .arm_i(arm), .clear_i(clr), .sel_we_i(swe), .sel_ch_i(sch),
        .sel_val_i(sval), .cnt_o(cnt), .ovf_o(ovf), .win_open_o(wopen),
        .win_done_o(wdone), .cfg_err_o(cerr)
    );

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;
    string cur_req = "R1";

    int mcnt[NUM_CH];
    int movf[NUM_CH];
    int msel[NUM_CH];
    int mst = 0; // 0 idle, 1 open, 2 done

    function automatic int cnt_of(int c);
        return int'(cnt[c*CNT_W +: CNT_W]);
    endfunction

    function automatic int model_err();
        if (mode == 2'd3) return 1;
        if (mode == 2'd1 || mode == 2'd2) begin
            foreach (msel[c]) if (msel[c] >= 1 && msel[c] <= NUM_EV) return 0;
            return 1;
        end
        return 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        for (int c = 0; c < NUM_CH; c++) begin
            chk(cur_req, $sformatf("model cnt%0d", c), cnt_of(c), mcnt[c]);
            chk(cur_req, $sformatf("model ovf%0d", c), int'(ovf[c]), movf[c]);
        end
        chk(cur_req, "model open", int'(wopen), int'(mst == 1));
        chk(cur_req, "model done", int'(wdone), int'(mst == 2));
        chk(cur_req, "model err", int'(cerr), model_err());
    endtask

    task automatic model_update();
        int err_now;
        int start, stop;
        err_now = model_err();
        start = (mode == 0) ? int'(go) : (mode == 1) ? int'(ta) : (mode == 2) ? int'(tb) : 0;
        stop  = (mode == 0) ? int'(brk) : (mode == 1) ? int'(tb) : (mode == 2) ? int'(ta) : 0;
        if (clr) begin
            foreach (mcnt[c]) begin mcnt[c] = 0; movf[c] = 0; end
        end else if (mst == 1 && cpu_clk_en) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (msel[c] >= 1 && msel[c] <= NUM_EV && ev[msel[c]-1]) begin
                    int inc = (msel[c] == BR_SEL) ? 2 : 1;
                    if (mcnt[c] + inc > MAXV) begin mcnt[c] = MAXV; movf[c] = 1; end
                    else mcnt[c] += inc;
                end
            end
        end
        if (clr || arm) mst = 0;
        else if (mst == 0 && start != 0 && err_now == 0) mst = 1;
        else if (mst == 1 && stop != 0) mst = 2;
        if (swe) msel[sch] = int'(sval);
    endtask

    task automatic tick();
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic setsel(int c, int code);
        swe = 1; sch = CH_W'(c); sval = SEL_W'(code);
        tick();
        swe = 0;
    endtask

    task automatic pulse_go();    go = 1;  tick(); go = 0;  endtask
    task automatic pulse_brk();   brk = 1; tick(); brk = 0; endtask
    task automatic pulse_a();     ta = 1;  tick(); ta = 0;  endtask
    task automatic pulse_b();     tb = 1;  tick(); tb = 0;  endtask
    task automatic pulse_arm();   arm = 1; tick(); arm = 0; endtask
    task automatic pulse_clr();   clr = 1; tick(); clr = 0; endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        foreach (mcnt[c]) begin mcnt[c] = 0; movf[c] = 0; msel[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        compare();
        for (int c = 0; c < NUM_CH; c++) chk("R1", "reset cnt", cnt_of(c), 0);
        chk("R1", "reset open", int'(wopen), 0);

        // R2 R3 R4 R5: run mode, mixed selects
        cur_req = "R2";
        setsel(0, 1);
        setsel(1, BR_SEL);
        setsel(2, 5);
        setsel(3, 12);
        ev = 8'h01;
        ticks(2);
        chk("R4", "idle no count", cnt_of(0), 0);
        cur_req = "R5";
        brk = 1; tick(); brk = 0;
        chk("R5", "brk in idle", int'(wopen), 0);
        pulse_go();
        chk("R5", "go opens", int'(wopen), 1);
        for (int i = 0; i < 10; i++) begin
            ev = 8'h01 | ((i < 3) ? 8'h04 : 8'h00) | ((i == 4 || i == 7) ? 8'h10 : 8'h00) | 8'h80;
            tick();
        end
        ev = 8'h01;
        pulse_brk();
        chk("R4", "cycle count incl close", cnt_of(0), 11);
        chk("R3", "branch by two", cnt_of(1), 6);
        chk("R2", "code 5 selects ev4", cnt_of(2), 2);
        chk("R2", "code above range disabled", cnt_of(3), 0);
        chk("R5", "brk closes", int'(wdone), 1);

        // R7: done ignores start, arm keeps counts
        cur_req = "R7";
        ev = '1;
        pulse_go();
        ticks(3);
        chk("R7", "done ignores go", int'(wopen), 0);
        chk("R7", "frozen count", cnt_of(0), 11);
        pulse_arm();
        chk("R7", "arm to idle", int'(wdone), 0);
        chk("R7", "arm keeps count", cnt_of(0), 11);

        // R9: clear
        cur_req = "R9";
        pulse_clr();
        chk("R9", "clear zeroes", cnt_of(1), 0);
        clr = 1; go = 1; tick(); clr = 0; go = 0;
        chk("R9", "clear beats go", int'(wopen), 0);
        chk("R2", "clear keeps select", int'(cerr), 0);

        // R6: A then B
        cur_req = "R6";
        ev = 8'h01;
        mode = 2'd1;
        pulse_b();
        chk("R6", "B ignored when idle", int'(wopen), 0);
        pulse_a();
        ticks(4);
        pulse_a();
        pulse_b();
        chk("R6", "A to B count", cnt_of(0), 6);
        chk("R6", "B closes", int'(wdone), 1);
        pulse_clr();
        mode = 2'd2;
        pulse_a();
        chk("R6", "A ignored mode2", int'(wopen), 0);
        pulse_b();
        ticks(2);
        pulse_a();
        chk("R6", "B to A count", cnt_of(0), 3);

        // R10: sleep
        cur_req = "R10";
        pulse_clr();
        mode = 2'd0;
        pulse_go();
        ticks(2);
        cpu_clk_en = 0;
        ticks(3);
        chk("R10", "sleep holds", cnt_of(0), 2);
        cpu_clk_en = 1;
        tick();
        pulse_brk();
        chk("R10", "resume count", cnt_of(0), 4);

        // R11: config error
        cur_req = "R11";
        pulse_clr();
        for (int c = 0; c < NUM_CH; c++) setsel(c, 0);
        mode = 2'd1;
        tick();
        chk("R11", "no channel err", int'(cerr), 1);
        pulse_a();
        chk("R11", "err blocks open", int'(wopen), 0);
        mode = 2'd3;
        tick();
        chk("R11", "mode3 err", int'(cerr), 1);
        mode = 2'd0;
        tick();
        chk("R11", "run mode no err", int'(cerr), 0);
        setsel(0, 1);
        mode = 2'd1;
        tick();
        chk("R11", "enabled no err", int'(cerr), 0);
        mode = 2'd0;

        // R8: saturation and sticky overflow
        cur_req = "R8";
        setsel(1, BR_SEL);
        pulse_clr();
        ev = 8'h05;
        pulse_go();
        ticks(31);
        chk("R8", "branch at 62", cnt_of(1), 62);
        chk("R8", "no ovf at 62", int'(ovf[1]), 0);
        tick();
        chk("R8", "branch saturates", cnt_of(1), MAXV);
        chk("R8", "ovf set", int'(ovf[1]), 1);
        ticks(40);
        chk("R8", "cycles saturate", cnt_of(0), MAXV);
        chk("R8", "ovf0 set", int'(ovf[0]), 1);
        pulse_brk();
        pulse_arm();
        chk("R8", "ovf survives arm", int'(ovf[0]), 1);
        pulse_clr();
        chk("R8", "clear resets ovf", int'(ovf[0]), 0);
        ticks(2);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule